// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks a frequency synthesizer setting that best serves two output clocks taken from one oscillator. A caller supplies a reference frequency and two requested output frequencies, all counted in 10 kHz units, and pulses `start`. The engine then tries one oscillator frequency at a time over a fixed window. For each trial it works out an odd feedback divider and, for each output, a post-divider chosen so that the output never runs faster than requested. It adds up the two shortfalls to give a score and keeps the trial with the lowest score.

All divisions share a single restoring divider that produces one quotient bit per cycle, so each trial takes roughly five divider runs. The search ends early in three cases: the feedback divider grows too large, a post-divider needs more than thirty, or a trial matches both requests exactly. When it ends, `done` pulses for one cycle. The chosen setting then stays on the outputs until the next search begins. If no trial was ever kept, the outputs read zero and `err` is raised.

Top module: `pll_div_search`

## Requirements
- R1: A `start` pulse while idle begins a search and raises `busy`. `busy` stays high until the cycle in which `done` pulses. A `start` pulse while `busy` is high is ignored, and the search in progress finishes with the values it was started with.
- R2: The trial oscillator frequency begins at the largest of 50000, `tgt_a` and `tgt_b`, and rises by 500 per trial. It goes up to and including 160000. If the starting value is already above 160000, the search ends with no trial made.
- R3: The reported feedback divider is floor(vco × 43663 / `ref_freq`) with bit 0 forced to 1.
- R4: A trial whose feedback divider (after bit 0 is forced) is greater than 0x3FFFFFF ends the search at once. The best earlier trial is kept.
- R5: For each output, the divider is first floor(vco / target). It is raised by one when floor(vco / divider) is still greater than the target. The resulting output, floor(vco / divider), is therefore never above the target.
- R6: A divider from R5 greater than 30 ends the search at once, and the best earlier trial is kept. Otherwise the reported post-divider is the R5 divider minus one, in 5 bits.
- R7: A trial's score is (tgt_a − achieved_a) + (tgt_b − achieved_b). A trial replaces the kept one only when its score is strictly lower. The kept score begins at 0x7FFFFFF, so among equal scores the earliest trial wins.
- R8: A trial with score zero is kept and ends the search at once.
- R9: If no trial is kept, `err` is 1 with `done`, and `fb_div`, `pdiv_a`, `pdiv_b` and `vco_freq` are all zero. Otherwise `err` is 0 and those outputs carry the kept trial.
- R10: `done` is a single-cycle pulse. The result outputs and `err` hold their values from that pulse until the next accepted `start`. They are all zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| ref_freq | input | FW (32) | Reference frequency, 10 kHz units |
| tgt_a | input | FW (32) | First requested output frequency |
| tgt_b | input | FW (32) | Second requested output frequency |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| err | output | 1 | No trial was kept |
| fb_div | output | FBW (26) | Chosen feedback divider |
| pdiv_a | output | PDW (5) | Chosen first post-divider, minus one |
| pdiv_b | output | PDW (5) | Chosen second post-divider, minus one |
| vco_freq | output | FW (32) | Chosen oscillator frequency |

## Verification
The properties assume that `ref_freq` and both targets are nonzero and stay constant from `start` to `done`. With a zero divisor the divider returns all ones, and that case is not covered. The bench draws the reference from 2000 to 2999, the first target from 2000 to 2599 and the second from 10000 to 59999. This keeps every divisor nonzero and makes the post-divider limit end most random searches well before the top of the window. Directed cases cover an exact match on the first trial, targets above the window, a feedback overflow on the first trial and midway through, and a post-divider beyond thirty on the first trial.

// File: rtl/pll_srch_pkg.sv
package pll_srch_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FB,
    S_QUO,
    S_ACH,
    S_EVAL,
    S_FIN
  } srch_state_t;

  // True when floor(v / q) > t, i.e. v >= q * (t + 1); q is small (<= 31)
  function automatic logic needs_bump(input logic [63:0] q,
                                      input logic [63:0] t,
                                      input logic [63:0] v);
    return (q * (t + 64'd1)) <= v;
  endfunction

  function automatic logic [63:0] max3(input logic [63:0] x,
                                       input logic [63:0] y,
                                       input logic [63:0] z);
    logic [63:0] m;
    m = (x > y) ? x : y;
    return (m > z) ? m : z;
  endfunction

endpackage

// File: rtl/pll_srch_div.sv
module pll_srch_div #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_r;
  logic [W-1:0]  rem_r;
  logic [W-1:0]  dvs_r;
  logic [CW-1:0] cnt_r;
  logic [W:0]    shifted;
  logic          ge;
  logic [W:0]    diff;

  always_comb begin
    shifted = {rem_r, quo_r[W-1]};
    ge      = shifted >= {1'b0, dvs_r};
    diff    = shifted - {1'b0, dvs_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_r <= '0;
      rem_r <= '0;
      dvs_r <= '0;
      cnt_r <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo_r <= dividend;
        rem_r <= '0;
        dvs_r <= divisor;
        cnt_r <= CW'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        rem_r <= ge ? diff[W-1:0] : shifted[W-1:0];
        quo_r <= {quo_r[W-2:0], ge};
        cnt_r <= cnt_r - 1'b1;
        if (cnt_r == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_r;
endmodule

// File: rtl/pll_srch_best.sv
module pll_srch_best #(
  parameter int FW         = 32,
  parameter int FBW        = 26,
  parameter int PDW        = 5,
  parameter int SW         = 33,
  parameter int SCORE_INIT = 32'h7FFFFFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           cand_valid,
  input  logic [SW-1:0]  cand_score,
  input  logic [FBW-1:0] cand_fb,
  input  logic [PDW-1:0] cand_pa,
  input  logic [PDW-1:0] cand_pb,
  input  logic [FW-1:0]  cand_vco,
  output logic           accept,
  output logic           best_valid,
  output logic [SW-1:0]  best_score,
  output logic [FBW-1:0] best_fb,
  output logic [PDW-1:0] best_pa,
  output logic [PDW-1:0] best_pb,
  output logic [FW-1:0]  best_vco
);
  assign accept = cand_valid && (cand_score < best_score);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_valid <= 1'b0;
      best_score <= SW'(SCORE_INIT);
      best_fb    <= '0;
      best_pa    <= '0;
      best_pb    <= '0;
      best_vco   <= '0;
    end else if (clear) begin
      best_valid <= 1'b0;
      best_score <= SW'(SCORE_INIT);
      best_fb    <= '0;
      best_pa    <= '0;
      best_pb    <= '0;
      best_vco   <= '0;
    end else if (accept) begin
      best_valid <= 1'b1;
      best_score <= cand_score;
      best_fb    <= cand_fb;
      best_pa    <= cand_pa;
      best_pb    <= cand_pb;
      best_vco   <= cand_vco;
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int          FW         = 32,
  parameter int          DW         = 40,
  parameter int          FBW        = 26,
  parameter int          PDW        = 5,
  parameter int          VCO_MIN    = 50000,
  parameter int          VCO_MAX    = 160000,
  parameter int          VCO_STEP   = 500,
  parameter int          FB_MULT    = 43663,
  parameter logic [63:0] FB_LIMIT   = 64'h3FF_FFFF,
  parameter int          PD_MAX     = 30,
  parameter int          SCORE_INIT = 32'h7FFFFFF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [FW-1:0]  ref_freq,
  input  logic [FW-1:0]  tgt_a,
  input  logic [FW-1:0]  tgt_b,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [FBW-1:0] fb_div,
  output logic [PDW-1:0] pdiv_a,
  output logic [PDW-1:0] pdiv_b,
  output logic [FW-1:0]  vco_freq
);
  import pll_srch_pkg::*;

  localparam int SW = FW + 1;
  localparam int RW = PDW + 1;

  srch_state_t   state;
  logic          waiting;
  logic          sel_b;
  logic [FW-1:0] ref_r, ta_r, tb_r, vco_r;
  logic [FW-1:0] ach_a, ach_b;
  logic [FBW-1:0] fb_r;
  logic [PDW-1:0] pa_r, pb_r;
  logic [RW-1:0]  raw_r;

  logic          div_go, div_busy, div_done;
  logic [DW-1:0] div_dvd, div_dvs, div_q;

  // named internal events for the checker
  logic          go;
  logic          ev_fb_over, ev_pd_over, ev_eval, ev_zero, ev_accept, ev_top;
  logic [FW-1:0] cur_t;
  logic          bump;
  logic [RW-1:0] raw_w;
  logic [SW-1:0] score;
  logic [63:0]   vco0, vco_nxt;

  logic           best_valid;
  logic [SW-1:0]  best_score;
  logic [FBW-1:0] best_fb;
  logic [PDW-1:0] best_pa, best_pb;
  logic [FW-1:0]  best_vco;

  always_comb begin
    cur_t   = sel_b ? tb_r : ta_r;
    div_dvd = '0;
    div_dvs = '0;
    case (state)
      S_FB:  begin div_dvd = DW'(vco_r) * DW'(FB_MULT); div_dvs = DW'(ref_r); end
      S_QUO: begin div_dvd = DW'(vco_r); div_dvs = DW'(cur_t); end
      S_ACH: begin div_dvd = DW'(vco_r); div_dvs = DW'(raw_r); end
      default: ;
    endcase
    div_go  = (state == S_FB || state == S_QUO || state == S_ACH) && !waiting;
    go      = start && !busy;
    bump    = needs_bump(64'(div_q[RW-1:0]), 64'(cur_t), 64'(vco_r));
    raw_w   = div_q[RW-1:0] + RW'(bump);
    ev_fb_over = (state == S_FB) && waiting && div_done &&
                 ((64'(div_q) | 64'd1) > FB_LIMIT);
    ev_pd_over = (state == S_QUO) && waiting && div_done &&
                 ((div_q > DW'(PD_MAX)) || (raw_w > RW'(PD_MAX)));
    score   = (SW'(ta_r) - SW'(ach_a)) + (SW'(tb_r) - SW'(ach_b));
    ev_eval = (state == S_EVAL);
    ev_zero = ev_eval && (score == '0);
    vco0    = max3(64'(VCO_MIN), 64'(tgt_a), 64'(tgt_b));
    vco_nxt = 64'(vco_r) + 64'(VCO_STEP);
    ev_top  = vco_nxt > 64'(VCO_MAX);
  end

  pll_srch_div #(.W(DW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_go),
    .dividend (div_dvd),
    .divisor  (div_dvs),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_q)
  );

  pll_srch_best #(
    .FW(FW), .FBW(FBW), .PDW(PDW), .SW(SW), .SCORE_INIT(SCORE_INIT)
  ) u_best (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (go),
    .cand_valid (ev_eval),
    .cand_score (score),
    .cand_fb    (fb_r),
    .cand_pa    (pa_r),
    .cand_pb    (pb_r),
    .cand_vco   (vco_r),
    .accept     (ev_accept),
    .best_valid (best_valid),
    .best_score (best_score),
    .best_fb    (best_fb),
    .best_pa    (best_pa),
    .best_pb    (best_pb),
    .best_vco   (best_vco)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      waiting  <= 1'b0;
      sel_b    <= 1'b0;
      ref_r    <= '0;
      ta_r     <= '0;
      tb_r     <= '0;
      vco_r    <= '0;
      ach_a    <= '0;
      ach_b    <= '0;
      fb_r     <= '0;
      pa_r     <= '0;
      pb_r     <= '0;
      raw_r    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      fb_div   <= '0;
      pdiv_a   <= '0;
      pdiv_b   <= '0;
      vco_freq <= '0;
    end else begin
      done <= 1'b0;
      if (div_go) waiting <= 1'b1;
      case (state)
        S_IDLE: if (go) begin
          busy  <= 1'b1;
          ref_r <= ref_freq;
          ta_r  <= tgt_a;
          tb_r  <= tgt_b;
          vco_r <= FW'(vco0);
          state <= (vco0 > 64'(VCO_MAX)) ? S_FIN : S_FB;
        end
        S_FB: if (waiting && div_done) begin
          waiting <= 1'b0;
          fb_r    <= div_q[FBW-1:0] | FBW'(1);
          sel_b   <= 1'b0;
          state   <= ev_fb_over ? S_FIN : S_QUO;
        end
        S_QUO: if (waiting && div_done) begin
          waiting <= 1'b0;
          raw_r   <= raw_w;
          if (sel_b) pb_r <= PDW'(raw_w - RW'(1));
          else       pa_r <= PDW'(raw_w - RW'(1));
          state   <= ev_pd_over ? S_FIN : S_ACH;
        end
        S_ACH: if (waiting && div_done) begin
          waiting <= 1'b0;
          if (sel_b) begin
            ach_b <= div_q[FW-1:0];
            state <= S_EVAL;
          end else begin
            ach_a <= div_q[FW-1:0];
            sel_b <= 1'b1;
            state <= S_QUO;
          end
        end
        S_EVAL: begin
          vco_r <= FW'(vco_nxt);
          state <= (ev_zero || ev_top) ? S_FIN : S_FB;
        end
        S_FIN: begin
          busy     <= 1'b0;
          done     <= 1'b1;
          err      <= !best_valid;
          fb_div   <= best_fb;
          pdiv_a   <= best_pa;
          pdiv_b   <= best_pb;
          vco_freq <= best_vco;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int FW      = 32,
  parameter int FBW     = 26,
  parameter int PDW     = 5,
  parameter int SW      = 33,
  parameter int VCO_MIN = 50000,
  parameter int VCO_MAX = 160000,
  parameter int PD_MAX  = 30
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           err,
  input logic [FBW-1:0] fb_div,
  input logic [PDW-1:0] pdiv_a,
  input logic [PDW-1:0] pdiv_b,
  input logic [FW-1:0]  vco_freq,
  input logic           ev_accept,
  input logic [SW-1:0]  best_score
);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r1_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  a_r3_fb_odd: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> fb_div[0]);
  a_r6_pdiv_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (pdiv_a <= PDW'(PD_MAX - 1) && pdiv_b <= PDW'(PD_MAX - 1)));
  a_r2_vco_window: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (vco_freq >= FW'(VCO_MIN) && vco_freq <= FW'(VCO_MAX)));
  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (fb_div == '0 && pdiv_a == '0 && pdiv_b == '0 && vco_freq == '0));
  a_r7_strict_improve: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (best_score < $past(best_score)));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done) |-> ($stable(fb_div) && $stable(vco_freq) && $stable(err)));
endmodule

bind pll_div_search pll_div_search_chk #(
  .FW(FW), .FBW(FBW), .PDW(PDW), .SW(FW + 1),
  .VCO_MIN(VCO_MIN), .VCO_MAX(VCO_MAX), .PD_MAX(PD_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .fb_div     (fb_div),
  .pdiv_a     (pdiv_a),
  .pdiv_b     (pdiv_b),
  .vco_freq   (vco_freq),
  .ev_accept  (ev_accept),
  .best_score (best_score)
);

// File: tb/pll_div_search_tb.sv
module pll_div_search_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_freq = '0, tgt_a = '0, tgt_b = '0;
  logic        busy, done, err;
  logic [25:0] fb_div;
  logic [4:0]  pdiv_a, pdiv_b;
  logic [31:0] vco_freq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pll_div_search u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_freq(ref_freq),
    .tgt_a(tgt_a), .tgt_b(tgt_b), .busy(busy), .done(done), .err(err),
    .fb_div(fb_div), .pdiv_a(pdiv_a), .pdiv_b(pdiv_b), .vco_freq(vco_freq)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Post-divider rounded so that the output stays at or below the target
  function automatic longint post_div(input longint v, input longint t);
    longint d;
    d = v / t;
    if (v / d > t) d++;
    return d;
  endfunction

  task automatic model(input longint rf, input longint a, input longint b,
                       output longint m_fb, output longint m_pa,
                       output longint m_pb, output longint m_vco,
                       output longint m_err);
    longint best, v, f, da, db, s;
    best = 64'h7FFFFFF; m_fb = 0; m_pa = 0; m_pb = 0; m_vco = 0; m_err = 1;
    v = 50000;
    if (a > v) v = a;
    if (b > v) v = b;
    while (v <= 160000) begin
      f = ((v * 43663) / rf) | 1;
      if (f > 64'h3FFFFFF) break;
      da = post_div(v, a);
      if (da > 30) break;
      db = post_div(v, b);
      if (db > 30) break;
      s = (a - v / da) + (b - v / db);
      if (s < best) begin
        best = s; m_fb = f; m_pa = da - 1; m_pb = db - 1; m_vco = v; m_err = 0;
      end
      if (s == 0) break;
      v += 500;
    end
  endtask

  task automatic kick(input longint rf, input longint a, input longint b);
    @(negedge clk);
    ref_freq = 32'(rf); tgt_a = 32'(a); tgt_b = 32'(b); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    ok = 1'b0;
    while (n < 60000) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
      n++;
    end
  endtask

  task automatic compare(input string tag, input longint rf,
                         input longint a, input longint b);
    longint e_fb, e_pa, e_pb, e_vco, e_err;
    model(rf, a, b, e_fb, e_pa, e_pb, e_vco, e_err);
    check(tag, "err", longint'(err), e_err);
    check(tag, "fb_div", longint'(fb_div), e_fb);
    check(tag, "pdiv_a", longint'(pdiv_a), e_pa);
    check(tag, "pdiv_b", longint'(pdiv_b), e_pb);
    check(tag, "vco_freq", longint'(vco_freq), e_vco);
    check(tag, "busy_low_at_done", longint'(busy), 0);
  endtask

  task automatic run(input string tag, input longint rf,
                     input longint a, input longint b);
    bit ok;
    kick(rf, a, b);
    wait_done(ok);
    check(tag, "done_seen", longint'(ok), 1);
    compare(tag, rf, a, b);
  endtask

  initial begin
    #(1900000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unused;
    bit ok;
    unused = $urandom(32'd9127);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    check("R10", "reset busy", longint'(busy), 0);
    check("R10", "reset done", longint'(done), 0);
    check("R10", "reset fb_div", longint'(fb_div), 0);
    check("R10", "reset vco_freq", longint'(vco_freq), 0);

    // R8 R5: exact match on the first trial
    run("R8", 2700, 25000, 50000);
    check("R8", "zero-score vco", longint'(vco_freq), 50000);
    check("R5", "pdiv_a exact", longint'(pdiv_a), 1);
    // R10: outputs hold after the done pulse
    repeat (7) @(negedge clk);
    check("R10", "done one cycle", longint'(done), 0);
    check("R10", "hold vco_freq", longint'(vco_freq), 50000);

    // R2 R9: targets above the window
    run("R2", 2700, 170000, 20000);
    check("R9", "err above window", longint'(err), 1);

    // R6 R9: post-divider above thirty on the first trial
    run("R6", 2700, 1000, 1000);
    check("R9", "err on pdiv limit", longint'(err), 1);

    // R4 R9: feedback overflow on the first trial
    run("R4", 30, 20000, 30000);
    check("R9", "err on fb overflow", longint'(err), 1);

    // R4 R1 R3 R7: overflow midway; a start while busy is ignored
    kick(50, 20000, 30000);
    repeat (5) @(negedge clk);
    ref_freq = 32'd2700; tgt_a = 32'd25000; tgt_b = 32'd50000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1", "busy during search", longint'(busy), 1);
    wait_done(ok);
    check("R1", "done_seen", longint'(ok), 1);
    compare("R1", 50, 20000, 30000);
    check("R3", "fb odd", longint'(fb_div[0]), 1);

    // R3 R5 R6 R7: constrained random
    for (int i = 0; i < 5; i++) begin
      longint rf, a, b;
      rf = 2000 + longint'($urandom % 1000);
      a  = 2000 + longint'($urandom % 600);
      b  = 10000 + longint'($urandom % 50000);
      run("R7", rf, a, b);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule